// File: doc/BRIEF.md
# Multi-core IPI register bank

This block holds the inter-processor interrupt state for a cluster of cores. Every core owns a private set of registers: a 32-bit pending status word, a 32-bit enable word, a write-only set port, a write-only clear port and eight 32-bit mailbox words. Each request carries a requester ID, and that ID selects which core's set is read or written. Every core has one level-sensitive interrupt line driven from its own status and enable words.

A core raises an interrupt in another core through a send register. The command word names a target core and a vector number. Its effect is the same as a write of a single bit to the target's set port. Requests from a requester ID at or above the configured core count get a decode error. So do send commands aimed at such a core. The request interface is a single-cycle strobe, and every request gets a response one cycle later.

Register offsets, decoded from address bits [7:0]: status 0x00, enable 0x04, set 0x08, clear 0x0C, mailbox words 0x20 to 0x3C, send 0x40. Response codes: 2'b00 accepted, 2'b01 decode error, 2'b10 write to read-only status ignored.

Top module: `ipi_bank`

## Requirements
- R1: While `rst` is high and after it is released, every status, enable and mailbox word reads zero, every `irq` bit is low and `rspValid` is low.
- R2: Each request with `reqValid` high produces `rspValid` high exactly one cycle later, together with `rspCode` and, for reads, `rspData`. No response appears without a request.
- R3: A request whose `reqId` is at or above NUM_CORES returns code 2'b01 and changes no register and no `irq` bit.
- R4: Only `reqAddr[7:0]` selects the register. Address bits above bit 7 have no effect.
- R5: A write to status (0x00) returns code 2'b10 and leaves status unchanged. A read returns the current pending bits.
- R6: Reads of set (0x08), clear (0x0C) and send (0x40) return zero. An offset with no register reads zero and is not changed by a write; such an access returns code 2'b00.
- R7: A write to set ORs the data into status. The core's `irq` then goes high if the new status ANDed with enable is nonzero. Otherwise `irq` keeps its value.
- R8: A write to clear removes the written bits from status. `irq` goes low only if the new status is zero and enable is nonzero. Otherwise `irq` keeps its value, even when status has become zero.
- R9: A write to enable (0x04) stores the word and never changes `irq` by itself.
- R10: Offsets 0x20 to 0x3C hold the requester's eight mailbox words. The word index is (offset - 0x20) >> 2. Each word is private to its core.
- R11: A write to send (0x40) takes the target core from data bits [25:16] and the vector from bits [4:0]. It acts exactly like a write of (1 << vector) to the target core's set port, including the R7 interrupt rule.
- R12: A send whose target is at or above NUM_CORES returns code 2'b01 and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqId | input | REQ_W | Requester core index |
| reqAddr | input | ADDR_W | Register address; bits [7:0] are decoded |
| reqData | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspCode | output | 2 | 00 accepted, 01 decode error, 10 read-only write |
| rspData | output | 32 | Read data |
| irq | output | NUM_CORES | Per-core level interrupt |

## Verification
The assertions check on every cycle that a response follows each request by one cycle and that out-of-range requesters get a decode error. They also check that status writes are flagged, that set and clear reads return zero, and that an interrupt line rises only after a set or send write and falls only after a clear write. Only the directed scenarios show the exact interrupt conditions. These include the cases where clearing to zero with enable off leaves the line high, and where turning enable on does not raise it. The scenarios also cover mailbox indexing and per-core isolation, the ignored upper address bits, and the routing of a send to another core's status.

// File: rtl/ipi_bank_pkg.sv
package ipi_bank_pkg;
  localparam int WORD_W     = 32;
  localparam int MBOX_WORDS = 8;
  localparam int MBOX_IDX_W = $clog2(MBOX_WORDS);
  localparam int TGT_W      = 10;
  localparam int TGT_LSB    = 16;
  localparam int VEC_W      = 5;

  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] OFF_SEND   = 8'h40;
  localparam logic [2:0] MBOX_PAGE  = 3'b001;

  typedef enum logic [1:0] {
    RSP_OK     = 2'b00,
    RSP_DECERR = 2'b01,
    RSP_ROWR   = 2'b10
  } rspCode_e;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_STATUS,
    RD_ENABLE,
    RD_MBOX
  } rdSel_e;

  typedef struct packed {
    logic                  rdEn;
    logic                  enWr;
    logic                  setWr;
    logic                  clrWr;
    logic                  mbWr;
    rdSel_e                rdSel;
    logic [MBOX_IDX_W-1:0] mbIdx;
  } strobe_t;
endpackage

// File: rtl/ipi_bank_ctrl.sv
module ipi_bank_ctrl
  import ipi_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int REQ_W     = 10,
  parameter int ADDR_W    = 12,
  parameter int CORE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [REQ_W-1:0]  reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  output strobe_t           strb,
  output logic [CORE_W-1:0] coreIdx,
  output logic [WORD_W-1:0] wrVal,
  output logic              rspValid,
  output rspCode_e          rspCode
);
  localparam logic [REQ_W-1:0] REQ_LIM = REQ_W'(NUM_CORES);
  localparam logic [TGT_W-1:0] TGT_LIM = TGT_W'(NUM_CORES);

  logic [7:0]       offset;
  logic             reqOk;
  logic [TGT_W-1:0] tgtId;
  logic [VEC_W-1:0] vecNum;
  logic             tgtOk;
  logic             isMbox;
  rspCode_e         codeNext;

  assign offset = reqAddr[7:0];
  assign reqOk  = reqId < REQ_LIM;
  assign tgtId  = reqData[TGT_LSB +: TGT_W];
  assign vecNum = reqData[VEC_W-1:0];
  assign tgtOk  = tgtId < TGT_LIM;
  assign isMbox = offset[7:5] == MBOX_PAGE;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    strb.mbIdx = offset[2 +: MBOX_IDX_W];
    coreIdx    = reqId[CORE_W-1:0];
    wrVal      = reqData;
    codeNext   = RSP_OK;
    if (reqValid) begin
      if (!reqOk) begin
        codeNext = RSP_DECERR;
      end else if (reqWrite) begin
        case (offset)
          OFF_STATUS: codeNext = RSP_ROWR;
          OFF_ENABLE: strb.enWr = 1'b1;
          OFF_SET:    strb.setWr = 1'b1;
          OFF_CLEAR:  strb.clrWr = 1'b1;
          OFF_SEND: begin
            if (tgtOk) begin
              strb.setWr = 1'b1;
              coreIdx    = tgtId[CORE_W-1:0];
              wrVal      = WORD_W'(1) << vecNum;
            end else begin
              codeNext = RSP_DECERR;
            end
          end
          default: strb.mbWr = isMbox;
        endcase
      end else begin
        strb.rdEn = 1'b1;
        case (offset)
          OFF_STATUS: strb.rdSel = RD_STATUS;
          OFF_ENABLE: strb.rdSel = RD_ENABLE;
          default:    strb.rdSel = isMbox ? RD_MBOX : RD_ZERO;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspCode  <= RSP_OK;
    end else begin
      rspValid <= reqValid;
      rspCode  <= codeNext;
    end
  end
endmodule

// File: rtl/ipi_bank_dp.sv
module ipi_bank_dp
  import ipi_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              strb,
  input  logic [CORE_W-1:0]    coreIdx,
  input  logic [WORD_W-1:0]    wrVal,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_CORES-1:0] irq
);
  logic [NUM_CORES-1:0][WORD_W-1:0]                 statusAll;
  logic [NUM_CORES-1:0][WORD_W-1:0]                 enableAll;
  logic [NUM_CORES-1:0][MBOX_WORDS-1:0][WORD_W-1:0] mboxAll;

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    logic                                 hit;
    logic [WORD_W-1:0]                    statusQ, enableQ, setVal, clrVal;
    logic [MBOX_WORDS-1:0][WORD_W-1:0]    mboxQ;
    logic                                 irqQ;

    assign hit    = coreIdx == CORE_W'(g);
    assign setVal = statusQ | wrVal;
    assign clrVal = statusQ & ~wrVal;

    always_ff @(posedge clk) begin
      if (rst) begin
        statusQ <= '0;
        enableQ <= '0;
        irqQ    <= 1'b0;
      end else if (hit) begin
        if (strb.enWr) enableQ <= wrVal;
        if (strb.setWr) begin
          statusQ <= setVal;
          if (setVal != '0 && (setVal & enableQ) != '0) irqQ <= 1'b1;
        end
        if (strb.clrWr) begin
          statusQ <= clrVal;
          if (clrVal == '0 && enableQ != '0) irqQ <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mboxQ <= '0;
      end else if (hit && strb.mbWr) begin
        mboxQ[strb.mbIdx] <= wrVal;
      end
    end

    assign statusAll[g] = statusQ;
    assign enableAll[g] = enableQ;
    assign mboxAll[g]   = mboxQ;
    assign irq[g]       = irqQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_STATUS: rdData <= statusAll[coreIdx];
        RD_ENABLE: rdData <= enableAll[coreIdx];
        RD_MBOX:   rdData <= mboxAll[coreIdx][strb.mbIdx];
        default:   rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
  import ipi_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int REQ_W     = 10,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [REQ_W-1:0]     reqId,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [31:0]          reqData,
  output logic                 rspValid,
  output logic [1:0]           rspCode,
  output logic [31:0]          rspData,
  output logic [NUM_CORES-1:0] irq
);
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  if (NUM_CORES < 1) begin : gBadCount
    initial $error("ipi_bank: NUM_CORES must be at least 1");
  end

  strobe_t           strb;
  logic [CORE_W-1:0] coreIdx;
  logic [WORD_W-1:0] wrVal;
  rspCode_e          codeQ;

  ipi_bank_ctrl #(
    .NUM_CORES(NUM_CORES), .REQ_W(REQ_W), .ADDR_W(ADDR_W), .CORE_W(CORE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqId(reqId), .reqAddr(reqAddr), .reqData(reqData),
    .strb(strb), .coreIdx(coreIdx), .wrVal(wrVal),
    .rspValid(rspValid), .rspCode(codeQ)
  );

  ipi_bank_dp #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .coreIdx(coreIdx), .wrVal(wrVal),
    .rdData(rspData), .irq(irq)
  );

  assign rspCode = codeQ;
endmodule

// File: rtl/ipi_bank_chk.sv
module ipi_bank_chk
  import ipi_bank_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int REQ_W     = 10,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic [REQ_W-1:0]     reqId,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic [31:0]          reqData,
  input logic                 rspValid,
  input logic [1:0]           rspCode,
  input logic [31:0]          rspData,
  input logic [NUM_CORES-1:0] irq
);
  localparam logic [REQ_W-1:0] REQ_LIM = REQ_W'(NUM_CORES);

  logic inRange;
  assign inRange = reqValid && (reqId < REQ_LIM);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  assert_decerr_R3: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqId >= REQ_LIM) |=> (rspCode == 2'b01));

  assert_status_ro_R5: assert property (@(posedge clk) disable iff (rst)
    (inRange && reqWrite && reqAddr[7:0] == OFF_STATUS) |=> (rspCode == 2'b10));

  assert_port_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (inRange && !reqWrite &&
     (reqAddr[7:0] == OFF_SET || reqAddr[7:0] == OFF_CLEAR)) |=> (rspData == '0));

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq)) != '0) |->
      $past(inRange && reqWrite &&
            (reqAddr[7:0] == OFF_SET || reqAddr[7:0] == OFF_SEND)));

  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
    ((~irq & $past(irq)) != '0) |->
      $past(inRange && reqWrite && reqAddr[7:0] == OFF_CLEAR));
endmodule

bind ipi_bank ipi_bank_chk #(
  .NUM_CORES(NUM_CORES), .REQ_W(REQ_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/tb_ipi_bank.sv
`timescale 1ns/1ps
module tb_ipi_bank;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [9:0]    reqId = '0;
  logic [11:0]   reqAddr = '0;
  logic [31:0]   reqData = '0;
  logic          rspValid;
  logic [1:0]    rspCode;
  logic [31:0]   rspData;
  logic [NC-1:0] irq;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipi_bank #(.NUM_CORES(NC), .REQ_W(10), .ADDR_W(12)) dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nErrors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic access(input logic [9:0] id, input bit wr, input logic [11:0] addr,
                        input logic [31:0] data, output logic [1:0] code,
                        output logic [31:0] rdata, output logic vld);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqId = id; reqAddr = addr; reqData = data;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    vld = rspValid; code = rspCode; rdata = rspData;
  endtask

  task automatic wr(input string req, input logic [9:0] id, input logic [11:0] addr,
                    input logic [31:0] data, input logic [1:0] expCode);
    logic [1:0] c; logic [31:0] d; logic v;
    access(id, 1'b1, addr, data, c, d, v);
    chk({req, " code"}, {30'd0, c}, {30'd0, expCode});
  endtask

  task automatic rdChk(input string req, input logic [9:0] id, input logic [11:0] addr,
                       input logic [31:0] exp);
    logic [1:0] c; logic [31:0] d; logic v;
    access(id, 1'b0, addr, 32'h0, c, d, v);
    chk({req, " valid"}, {31'd0, v}, 32'd1);
    chk({req, " data"}, d, exp);
  endtask

  task automatic irqChk(input string req, input int core, input logic exp);
    chk(req, {31'd0, irq[core]}, {31'd0, exp});
  endtask

  task automatic testReset;
    chk("R1 rspValid in reset", {31'd0, rspValid}, 32'd0);
    chk("R1 irq in reset", {28'd0, irq}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R2 no response idle", {31'd0, rspValid}, 32'd0);
    rdChk("R1 status", 10'd0, 12'h000, 32'h0);
    rdChk("R1 enable", 10'd0, 12'h004, 32'h0);
    rdChk("R1 mailbox", 10'd2, 12'h03C, 32'h0);
  endtask

  task automatic testSetClear;
    wr("R9 enable core1", 10'd1, 12'h004, 32'h5, 2'b00);
    wr("R7 set core1", 10'd1, 12'h008, 32'h2, 2'b00);
    irqChk("R7 masked set keeps irq low", 1, 1'b0);
    rdChk("R7 status after set", 10'd1, 12'h000, 32'h2);
    wr("R7 set core1", 10'd1, 12'h008, 32'h4, 2'b00);
    irqChk("R7 enabled set raises irq", 1, 1'b1);
    rdChk("R7 status ORed", 10'd1, 12'h000, 32'h6);
    rdChk("R6 set reads zero", 10'd1, 12'h008, 32'h0);
    rdChk("R6 clear reads zero", 10'd1, 12'h00C, 32'h0);
    wr("R8 partial clear", 10'd1, 12'h00C, 32'h4, 2'b00);
    irqChk("R8 nonzero status keeps irq", 1, 1'b1);
    rdChk("R8 status after clear", 10'd1, 12'h000, 32'h2);
    wr("R8 full clear", 10'd1, 12'h00C, 32'h2, 2'b00);
    irqChk("R8 zero status lowers irq", 1, 1'b0);
    irqChk("R7 core0 untouched", 0, 1'b0);
  endtask

  task automatic testAsym;
    wr("R7 set core2 disabled", 10'd2, 12'h008, 32'h1, 2'b00);
    irqChk("R7 enable zero no irq", 2, 1'b0);
    wr("R9 enable core2", 10'd2, 12'h004, 32'h1, 2'b00);
    irqChk("R9 enable write does not raise", 2, 1'b0);
    rdChk("R9 enable readback", 10'd2, 12'h004, 32'h1);
    wr("R7 set zero", 10'd2, 12'h008, 32'h0, 2'b00);
    irqChk("R7 set re-evaluates", 2, 1'b1);
    wr("R9 disable core2", 10'd2, 12'h004, 32'h0, 2'b00);
    irqChk("R9 disable does not lower", 2, 1'b1);
    wr("R8 clear with enable zero", 10'd2, 12'h00C, 32'h1, 2'b00);
    irqChk("R8 enable zero keeps irq", 2, 1'b1);
    rdChk("R8 status zero", 10'd2, 12'h000, 32'h0);
    wr("R9 enable core2", 10'd2, 12'h004, 32'h1, 2'b00);
    wr("R8 clear zero bits", 10'd2, 12'h00C, 32'h0, 2'b00);
    irqChk("R8 zero status with enable lowers", 2, 1'b0);
  endtask

  task automatic testMailbox;
    for (int w = 0; w < 8; w++)
      wr("R10 mailbox write", 10'd3, 12'(12'h020 + 4 * w), 32'hA500_0000 | 32'(w), 2'b00);
    for (int w = 0; w < 8; w++)
      rdChk("R10 mailbox read", 10'd3, 12'(12'h020 + 4 * w), 32'hA500_0000 | 32'(w));
    rdChk("R10 other core isolated", 10'd0, 12'h028, 32'h0);
    wr("R4 upper address bits", 10'd0, 12'hF24, 32'h1234_5678, 2'b00);
    rdChk("R4 alias readback", 10'd0, 12'h024, 32'h1234_5678);
    rdChk("R4 upper bits on read", 10'd0, 12'h724, 32'h1234_5678);
  endtask

  task automatic testIllegal;
    wr("R5 status write", 10'd1, 12'h000, 32'hFFFF_FFFF, 2'b10);
    rdChk("R5 status unchanged", 10'd1, 12'h000, 32'h0);
    irqChk("R5 no irq", 1, 1'b0);
    wr("R6 unmapped write", 10'd0, 12'h010, 32'hDEAD_BEEF, 2'b00);
    rdChk("R6 unmapped reads zero", 10'd0, 12'h010, 32'h0);
    rdChk("R6 unmapped no side effect", 10'd0, 12'h004, 32'h0);
    wr("R3 out-of-range enable", 10'd4, 12'h004, 32'hFFFF_FFFF, 2'b01);
    wr("R3 out-of-range set", 10'd4, 12'h008, 32'hFFFF_FFFF, 2'b01);
    wr("R3 large id mailbox", 10'd1023, 12'h020, 32'h1, 2'b01);
    chk("R3 no irq", {28'd0, irq}, 32'd0);
    for (int c = 0; c < NC; c++) begin
      rdChk("R3 status unchanged", 10'(c), 12'h000, 32'h0);
      rdChk("R3 enable unchanged", 10'(c), 12'h004, (c == 1) ? 32'h5 : (c == 2) ? 32'h1 : 32'h0);
    end
    rdChk("R3 mailbox unchanged", 10'd0, 12'h020, 32'h0);
  endtask

  task automatic testSend;
    wr("R11 enable core3", 10'd3, 12'h004, 32'h0000_0020, 2'b00);
    wr("R11 send vector 5", 10'd0, 12'h040, (32'd3 << 16) | 32'd5, 2'b00);
    irqChk("R11 target irq", 3, 1'b1);
    irqChk("R11 sender irq unchanged", 0, 1'b0);
    rdChk("R11 target status", 10'd3, 12'h000, 32'h0000_0020);
    rdChk("R11 sender status", 10'd0, 12'h000, 32'h0);
    rdChk("R6 send reads zero", 10'd0, 12'h040, 32'h0);
    wr("R11 send vector 31", 10'd1, 12'h040, (32'd3 << 16) | 32'd31, 2'b00);
    rdChk("R11 vector 31", 10'd3, 12'h000, 32'h8000_0020);
    wr("R11 masked send", 10'd3, 12'h040, (32'd2 << 16) | 32'd4, 2'b00);
    irqChk("R11 masked target no irq", 2, 1'b0);
    rdChk("R11 masked status", 10'd2, 12'h000, 32'h0000_0010);
    wr("R12 target at limit", 10'd0, 12'h040, (32'd4 << 16) | 32'd1, 2'b01);
    wr("R12 target max id", 10'd0, 12'h040, (32'd1023 << 16) | 32'd1, 2'b01);
    for (int c = 0; c < 2; c++)
      rdChk("R12 no status change", 10'(c), 12'h000, 32'h0);
    chk("R12 irq unchanged", {28'd0, irq}, 32'h8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    testSetClear();
    testAsym();
    testMailbox();
    testIllegal();
    testSend();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule